// File: doc/BRIEF.md
# Successive-Approximation A-D Conversion Controller

This block is the digital side of an eight-input, 10-bit successive-approximation converter in a small microcontroller. Software reaches it through a byte-wide register bus with three addresses: a control register and two read-only result registers. The block drives a 3-bit input select to an analog multiplexer and a 10-bit trial code to a resistor-ladder DAC. It reads back a single comparator bit and, once the binary search is over, stores the code and pulses an interrupt request.

A conversion starts in one of two ways. Software can write the control register with its completion flag cleared. Hardware can start one through an external trigger pin, if the trigger is enabled. The trigger's active edge is taken from a polarity input that is shared with an interrupt pin's edge setting. Because of this, changing that polarity while the pin holds steady can look like an edge and start a conversion.

The result can be read in two ways. An 8-bit read is a single access to the low result address. A 10-bit read accesses the high address first and then the low address.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Bus address 0 is the control register. Its bits 2..0 choose the analog input, and code n (0..7) drives `ch_sel` to n when a conversion starts.
- R2: Control bit 3 is the completion flag. It reads 0 while a conversion runs and 1 when the block is idle. The control register reads 0x08 after reset.
- R3: Writing address 0 with bit 3 = 0 while idle starts a conversion. Writing it with bit 3 = 1 starts nothing.
- R4: When control bit 5 is 1, an active edge on `trig_pin` starts a conversion. The active edge is rising when `trig_pol` = 1 and falling when `trig_pol` = 0. When bit 5 is 0, the pin has no effect.
- R5: With the trigger enabled, a change of `trig_pol` that makes the polarity-adjusted pin level go from 0 to 1 starts a conversion, even though the pin itself stays steady.
- R6: A conversion lasts exactly 10*CLK_DIV clock cycles. In the cycle where the completion flag returns to 1, `irq` is high for exactly that one cycle.
- R7: A read strobe on address 1 that does not follow a read of address 2 returns result bits 9..2.
- R8: A read of address 2 returns {6'b0, result[9:8]}. The next read strobe on address 1 returns result bits 7..0. Address 3 reads 0.
- R9: Control bits 7, 6 and 4 read 0. Bit 5 reads back the value that was written to it.
- R10: The search goes from MSB to LSB and starts with trial code 0x200. Each trial bit is kept when `cmp_in` = 1 (input at or above the ladder voltage). With an ideal comparator, the final result equals the input code.
- R11: A start request that arrives during a conversion is ignored. `ch_sel` holds the value latched at start. A control write made during a conversion still updates the readable bits 2..0 and bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 result low, 2 result high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only controls the readout mode) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| trig_pin | input | 1 | External conversion trigger |
| trig_pol | input | 1 | Shared edge polarity: 1 rising, 0 falling |
| cmp_in | input | 1 | Comparator: 1 when input >= ladder voltage |
| ch_sel | output | 3 | Analog input select |
| dac_code | output | 10 | Trial code to the resistor ladder |
| irq | output | 1 | One-cycle conversion-complete request |

## Verification
A software start takes effect at the clock edge that captures the write. The completion flag and `irq` then change exactly 10*CLK_DIV edges later, so the bench samples the flag at the negative edge one cycle before that point and again at that point. Trigger starts pass through a synchronizer stage and an edge-detect stage, which adds two edges, so trigger checks look for a busy flag three cycles after the pin or polarity change and then poll for completion. Result reads are combinational, but the mode flag changes at the edge where a read strobe is captured, so each read is sampled within its strobe cycle and the next read comes in a later cycle.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       trig_pin,
  input  logic       trig_pol,
  input  logic       cmp_in,
  output logic [2:0] ch_sel,
  output logic [9:0] dac_code,
  output logic       irq
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [2:0]    ch_q;
  logic          trig_en;
  logic          busy;
  logic [3:0]    idx;
  logic [CW-1:0] cnt;
  logic [9:0]    res;
  logic          hi_armed;
  logic          trig_s;
  logic          eff_q;

  wire ctrl_wr    = bus_wr && bus_addr == 2'd0;
  wire eff        = trig_pol ? trig_s : ~trig_s;
  wire trig_start = trig_en && eff && !eff_q;
  wire sw_start   = ctrl_wr && !bus_wdata[3];
  wire start      = !busy && (sw_start || trig_start);
  wire step_end   = busy && cnt == CW'(CLK_DIV - 1);
  wire [9:0] kept = cmp_in ? dac_code : (dac_code & ~(10'd1 << idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= '0;
      trig_en  <= 1'b0;
      busy     <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      res      <= '0;
      hi_armed <= 1'b0;
      trig_s   <= 1'b0;
      eff_q    <= 1'b0;
      ch_sel   <= '0;
      dac_code <= '0;
      irq      <= 1'b0;
    end else begin
      trig_s <= trig_pin;
      eff_q  <= eff;
      irq    <= 1'b0;
      if (ctrl_wr) begin
        ch_q    <= bus_wdata[2:0];
        trig_en <= bus_wdata[5];
      end
      if (start) begin
        busy     <= 1'b1;
        ch_sel   <= ctrl_wr ? bus_wdata[2:0] : ch_q;
        dac_code <= 10'h200;
        idx      <= 4'd9;
        cnt      <= '0;
      end else if (step_end) begin
        cnt <= '0;
        if (idx == 4'd0) begin
          busy     <= 1'b0;
          res      <= kept;
          dac_code <= kept;
          irq      <= 1'b1;
        end else begin
          dac_code <= kept | (10'd1 << (idx - 4'd1));
          idx      <= idx - 4'd1;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (bus_rd && bus_addr == 2'd2) hi_armed <= 1'b1;
      else if (bus_rd && bus_addr == 2'd1) hi_armed <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {2'b00, trig_en, 1'b0, !busy, ch_q};
      2'd1:    bus_rdata = hi_armed ? res[7:0] : res[9:2];
      2'd2:    bus_rdata = {6'b0, res[9:8]};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic       irq,
  input logic [2:0] ch_sel,
  input logic [9:0] dac_code
);
  assert_irq_at_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_chsel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ch_sel));

  assert_first_trial_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == 10'h200);

  assert_high_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> bus_rdata[7:2] == 6'b0);

  assert_ctrl_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[7:6] == 2'b0 && !bus_rdata[4]));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .busy(busy), .irq(irq), .ch_sel(ch_sel), .dac_code(dac_code)
);

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
  localparam int D = 4;
  localparam int CONV = 10 * D;
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 10'd0}, {3'd1, 10'd1023}, {3'd2, 10'd512}, {3'd3, 10'd511},
    {3'd4, 10'd1}, {3'd5, 10'h2AA}, {3'd6, 10'h155}, {3'd7, 10'd700}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic trig_pin = 0, trig_pol = 1;
  logic cmp_in;
  logic [2:0] ch_sel;
  logic [9:0] dac_code;
  logic irq;
  logic [9:0] vin [8];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign cmp_in = vin[ch_sel] >= dac_code;

  sar_adc_ctrl #(.CLK_DIV(D)) i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_pin(trig_pin), .trig_pol(trig_pol),
    .cmp_in(cmp_in), .ch_sel(ch_sel), .dac_code(dac_code), .irq(irq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); peek(0, d);
      if (d[3]) break;
    end
  endtask

  task automatic fill(input logic [2:0] ch, input logic [9:0] v);
    for (int k = 0; k < 8; k++) vin[k] = v ^ 10'h3FF;
    vin[ch] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    for (int k = 0; k < 8; k++) vin[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(0, d);  check(d == 8'h08, "R2 reset control", d, 8'h08);
    check(irq == 0, "R6 reset irq", irq, 0);
    peek(1, d);  check(d == 8'h00, "R7 reset low", d, 0);
    peek(3, d);  check(d == 8'h00, "R8 addr3 zero", d, 0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] ch;
      logic [9:0] v;
      {ch, v} = VEC[i];
      fill(ch, v);
      wr(0, {5'b0, ch});
      check(ch_sel == ch, "R1 ch_sel", ch_sel, ch);
      repeat (CONV - 1) @(negedge clk);
      peek(0, d); check(d[3] == 0, "R2 flag low while running", d[3], 0);
      check(irq == 0, "R6 no early irq", irq, 0);
      @(negedge clk);
      peek(0, d); check(d[3] == 1, "R6 flag set at 10*CLK_DIV", d[3], 1);
      check(irq == 1, "R6 irq pulse", irq, 1);
      @(negedge clk);
      check(irq == 0, "R6 irq one cycle", irq, 0);
      rd(1, d);  check(d == v[9:2], "R7 R10 8-bit read", d, v[9:2]);
      rd(2, d);  check(d == {6'b0, v[9:8]}, "R8 high read", d, v[9:8]);
      rd(1, d2); check(d2 == v[7:0], "R8 R10 low after high", d2, v[7:0]);
      rd(1, d);  check(d == v[9:2], "R7 mode back to 8-bit", d, v[9:2]);
    end

    wr(0, 8'hFF);
    peek(0, d); check(d == 8'h2F, "R9 R3 unused bits, bit3=1 no start", d, 8'h2F);
    repeat (3) @(negedge clk);
    peek(0, d); check(d[3] == 1, "R3 write bit3=1 stays idle", d[3], 1);

    fill(3'd2, 10'd300);
    wr(0, 8'h0A);
    trig_pol = 1; trig_pin = 0;
    repeat (3) @(negedge clk);
    trig_pin = 1;
    repeat (3) @(negedge clk);
    peek(0, d); check(d[3] == 1, "R4 trigger disabled ignored", d[3], 1);
    trig_pin = 0;
    repeat (3) @(negedge clk);

    wr(0, 8'h2A);
    repeat (2) @(negedge clk);
    trig_pin = 1;
    repeat (3) @(negedge clk);
    peek(0, d); check(d[3] == 0, "R4 rising edge starts", d[3], 0);
    check(ch_sel == 3'd2, "R4 R1 trigger channel", ch_sel, 2);
    wait_idle();
    rd(1, d); check(d == 8'd75, "R4 trigger result", d, 75);

    trig_pol = 0; trig_pin = 1;
    repeat (3) @(negedge clk);
    wait_idle();
    fill(3'd2, 10'd800);
    trig_pin = 0;
    repeat (3) @(negedge clk);
    peek(0, d); check(d[3] == 0, "R4 falling edge starts", d[3], 0);
    wait_idle();
    rd(1, d); check(d == 8'd200, "R4 falling result", d, 200);

    trig_pol = 0; trig_pin = 1;
    repeat (3) @(negedge clk);
    wait_idle();
    fill(3'd2, 10'd40);
    trig_pol = 1;
    repeat (3) @(negedge clk);
    peek(0, d); check(d[3] == 0, "R5 polarity flip starts", d[3], 0);
    wait_idle();
    rd(1, d); check(d == 8'd10, "R5 result", d, 10);
    wr(0, 8'h08);
    trig_pin = 0;
    repeat (3) @(negedge clk);

    fill(3'd6, 10'd999);
    wr(0, 8'h06);
    repeat (10) @(negedge clk);
    wr(0, 8'h01);
    peek(0, d); check(d[2:0] == 3'd1, "R11 control bits updated", d[2:0], 1);
    check(ch_sel == 3'd6, "R11 ch_sel held", ch_sel, 6);
    repeat (CONV - 13) @(negedge clk);
    peek(0, d); check(d[3] == 0, "R11 restart ignored, still running", d[3], 0);
    @(negedge clk);
    peek(0, d); check(d[3] == 1, "R11 original length kept", d[3], 1);
    rd(2, d);  check(d == 8'd3, "R11 high bits of held channel", d, 3);
    rd(1, d);  check(d == 8'hE7, "R11 R10 low bits of held channel", d, 8'hE7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule